// File: doc/BRIEF.md
# Chip-Select Gated Serial Result Output Port

This block is a slave serial output port for a converter. The conversion engine hands it finished result words through a one-cycle valid pulse. The port keeps the latest word in a holding register and pulls a data-ready flag low. It then presents the word MSB first on a data line that is driven only while the host's chip-select is low. The host supplies the serial clock, which may run asynchronously to the system clock. The chip-select and serial clock inputs are each synchronized by two flip-flops before any logic uses them. The host must therefore keep chip-select low for at least two system clocks plus a margin before it toggles the serial clock.

When chip-select falls while a word is pending, the line comes out of high impedance with the MSB already on it. Shifting is not yet enabled at that point. The first rising serial-clock edge arms the shifter, and each falling edge after that moves to the next lower bit. A falling edge that arrives before arming is ignored, which covers a host whose serial clock idles high. The falling edge after the LSB releases the line and raises data-ready again.

A new result replaces the held word only when the port is empty or chip-select is high; otherwise the result is dropped. Raising chip-select partway through a word releases the line and keeps the word pending, so the next read starts again at the MSB. The tri-state line is represented by a data output `sdo` and an enable output `sdoOe`.

Top module: `csq_out_port`

## Requirements
- R1: After reset `drdyN` is 1 and `sdoOe` is 0. A `resValid` pulse into an empty port loads `resData` and drives `drdyN` to 0 on the next clock.
- R2: Once chip-select is low and a word is pending, `sdoOe` becomes 1 within three system clocks with `sdo` equal to bit WIDTH-1 of the word. This holds whether chip-select falls before or after the word arrives. While `sdoOe` is 0, `sdo` is 0.
- R3: Once armed by a rising serial-clock edge, each falling serial-clock edge puts the next lower bit on `sdo`, so the host reads the word MSB first.
- R4: If the serial clock is high when the MSB is first presented, the first falling edge is ignored and `sdo` keeps the MSB.
- R5: The falling serial-clock edge that follows the LSB drives `sdoOe` to 0 and `drdyN` to 1.
- R6: A result that arrives while a word is pending and chip-select is low is discarded. A result that arrives while chip-select is high replaces the pending word.
- R7: Raising chip-select mid-word drives `sdoOe` to 0 and leaves `drdyN` at 0. The next low period of chip-select restarts the word at the MSB.
- R8: WIDTH must be 16 or 20. Any other value is rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resValid | input | 1 | One-cycle pulse: a new result is on resData |
| resData | input | WIDTH | Conversion result word |
| csN | input | 1 | Host chip-select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdo | output | 1 | Serial data, valid while sdoOe is 1 |
| sdoOe | output | 1 | Drive enable for the serial data line (0 = high impedance) |
| drdyN | output | 1 | Data ready, active low |

## Verification
The hardest situation to reach is the unarmed state with the serial clock already high. The host has to raise the clock before it drops chip-select, and then issue a falling edge that must be ignored. The bench drives that sequence directly and checks that the MSB stays on the line before the arming rising edge. It also aborts a read partway through a word and reads the same word again from the MSB. It injects results during an active read and while chip-select is high, then reads the words back to tell a discarded result from an accepted one.

// File: rtl/csq_port_pkg.sv
package csq_port_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESENT = 2'd1,
    ST_ARMED   = 2'd2
  } port_state_e;

  typedef struct packed {
    logic loadHold;
    logic startWord;
    logic shiftBit;
    logic finish;
    logic abort;
  } ctl_strobe_t;

endpackage

// File: rtl/csq_port_sync.sv
module csq_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  output logic csLow,
  output logic sclkRise,
  output logic sclkFall
);
  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] sclkPipe;
  logic              sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[STAGES-2:0], sclk};
      sclkPrev <= sclkPipe[STAGES-1];
    end
  end

  assign csLow    = !csPipe[STAGES-1];
  assign sclkRise = sclkPipe[STAGES-1] && !sclkPrev;
  assign sclkFall = !sclkPipe[STAGES-1] && sclkPrev;
endmodule

// File: rtl/csq_port_ctrl.sv
module csq_port_ctrl
  import csq_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csLow,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        resValid,
  input  logic        hasData,
  input  logic        lastBit,
  output ctl_strobe_t strobe,
  output logic        driveEn
);
  port_state_e state, stateNext;

  always_comb begin
    strobe          = '0;
    stateNext       = state;
    strobe.loadHold = resValid && (!hasData || !csLow);
    unique case (state)
      ST_IDLE: begin
        if (csLow && hasData) begin
          stateNext        = ST_PRESENT;
          strobe.startWord = 1'b1;
        end
      end
      ST_PRESENT: begin
        if (!csLow) begin
          stateNext    = ST_IDLE;
          strobe.abort = 1'b1;
        end else if (sclkRise) begin
          stateNext = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (!csLow) begin
          stateNext    = ST_IDLE;
          strobe.abort = 1'b1;
        end else if (sclkFall) begin
          if (lastBit) begin
            stateNext     = ST_IDLE;
            strobe.finish = 1'b1;
          end else begin
            strobe.shiftBit = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign driveEn = (state != ST_IDLE);
endmodule

// File: rtl/csq_port_datapath.sv
module csq_port_datapath
  import csq_port_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strobe,
  input  logic [WIDTH-1:0] resData,
  output logic             hasData,
  output logic             lastBit,
  output logic             serialBit,
  output logic [WIDTH-1:0] holdWord
);
  localparam int CNTW = $clog2(WIDTH);
  localparam logic [CNTW-1:0] LAST_CNT = CNTW'(WIDTH - 1);

  logic [WIDTH-1:0] shiftReg;
  logic [CNTW-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      hasData  <= 1'b0;
    end else if (strobe.loadHold) begin
      holdWord <= resData;
      hasData  <= 1'b1;
    end else if (strobe.finish) begin
      hasData  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.startWord) begin
      shiftReg <= holdWord;
      bitCnt   <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[WIDTH-2:0], 1'b0};
      bitCnt   <= bitCnt + 1'b1;
    end else if (strobe.abort || strobe.finish) begin
      bitCnt   <= '0;
    end
  end

  assign lastBit   = (bitCnt == LAST_CNT);
  assign serialBit = shiftReg[WIDTH-1];
endmodule

// File: rtl/csq_out_port.sv
module csq_out_port
  import csq_port_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resValid,
  input  logic [WIDTH-1:0] resData,
  input  logic             csN,
  input  logic             sclk,
  output logic             sdo,
  output logic             sdoOe,
  output logic             drdyN
);
  if (WIDTH != 16 && WIDTH != 20) begin : g_bad_width
    $error("R8: WIDTH must be 16 or 20");
  end

  logic             csLow, sclkRise, sclkFall;
  logic             hasData, lastBit, serialBit, driveEn;
  logic [WIDTH-1:0] holdWord;
  ctl_strobe_t      strobe;

  csq_port_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .csLow(csLow), .sclkRise(sclkRise), .sclkFall(sclkFall)
  );

  csq_port_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csLow(csLow), .sclkRise(sclkRise),
    .sclkFall(sclkFall), .resValid(resValid), .hasData(hasData),
    .lastBit(lastBit), .strobe(strobe), .driveEn(driveEn)
  );

  csq_port_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resData(resData),
    .hasData(hasData), .lastBit(lastBit), .serialBit(serialBit),
    .holdWord(holdWord)
  );

  assign sdoOe = driveEn;
  assign sdo   = driveEn ? serialBit : 1'b0;
  assign drdyN = !hasData;
endmodule

// File: rtl/csq_out_port_chk.sv
module csq_out_port_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             resValid,
  input logic             sdo,
  input logic             sdoOe,
  input logic             drdyN,
  input logic [WIDTH-1:0] holdWord
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (drdyN && !sdoOe)); // R1

  AST_READY_FROM_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drdyN) |-> $past(resValid)); // R1

  AST_DRIVE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> !drdyN); // R2

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoOe) |-> (sdo == holdWord[WIDTH-1])); // R2

  AST_QUIET_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !sdoOe |-> !sdo); // R2

  AST_EMPTY_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drdyN) |-> $fell(sdoOe)); // R5

  AST_HOLD_FROZEN_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && $past(sdoOe)) |-> $stable(holdWord)); // R6

  AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !sdoOe); // R7
endmodule

bind csq_out_port csq_out_port_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/csq_out_port_tb_top.sv
`timescale 1ns/1ps
module csq_out_port_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         resValid = 1'b0;
  logic [W-1:0] resData = '0;
  logic         csN = 1'b1;
  logic         sclk = 1'b0;
  logic         sdo, sdoOe, drdyN;
  int           checks = 0;
  int           failures = 0;
  bit           finished = 1'b0;

  always #10 clk = ~clk;

  csq_out_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resData(resData),
    .csN(csN), .sclk(sclk), .sdo(sdo), .sdoOe(sdoOe), .drdyN(drdyN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pushResult(input logic [W-1:0] val);
    @(negedge clk);
    resData  = val;
    resValid = 1'b1;
    @(negedge clk);
    resValid = 1'b0;
    settle();
  endtask

  task automatic clkEdge(input logic lvl);
    sclk = lvl;
    settle();
  endtask

  // Reads a presented word; if sclk is high on entry the first fall must be ignored.
  task automatic readWord(output logic [W-1:0] got);
    got = '0;
    got[W-1] = sdo;
    if (sclk) begin
      clkEdge(1'b0);
      chk("R4 leading fall ignored", {31'd0, sdo}, {31'd0, got[W-1]});
    end
    for (int i = W - 2; i >= 0; i--) begin
      clkEdge(1'b1);
      clkEdge(1'b0);
      got[i] = sdo;
    end
    clkEdge(1'b1);
    clkEdge(1'b0);
    chk("R5 line released after LSB", {31'd0, sdoOe}, 32'd0);
    chk("R5 ready high after LSB", {31'd0, drdyN}, 32'd1);
  endtask

  task automatic tReset();
    chk("R1 reset drdyN", {31'd0, drdyN}, 32'd1);
    chk("R1 reset sdoOe", {31'd0, sdoOe}, 32'd0);
  endtask

  task automatic tReadLowIdle();
    logic [W-1:0] w = W'(32'hA5C3_96E1);
    logic [W-1:0] got;
    pushResult(w);
    chk("R1 ready after load", {31'd0, drdyN}, 32'd0);
    csN = 1'b0;
    settle();
    chk("R2 drive on select", {31'd0, sdoOe}, 32'd1);
    chk("R2 MSB presented", {31'd0, sdo}, {31'd0, w[W-1]});
    readWord(got);
    chk("R3 word low-idle clock", 32'(got), 32'(w));
    csN = 1'b1;
    settle();
  endtask

  task automatic tReadHighIdle();
    logic [W-1:0] w = W'(32'h3C5A_8001);
    logic [W-1:0] got;
    pushResult(w);
    sclk = 1'b1;
    settle();
    csN = 1'b0;
    settle();
    chk("R2 MSB with clock high", {31'd0, sdo}, {31'd0, w[W-1]});
    readWord(got);
    chk("R4 word high-idle clock", 32'(got), 32'(w));
    csN = 1'b1;
    settle();
  endtask

  task automatic tDiscard();
    logic [W-1:0] w = W'(32'h6F0D_1234);
    logic [W-1:0] got;
    pushResult(w);
    csN = 1'b0;
    settle();
    pushResult(~w);
    readWord(got);
    chk("R6 result dropped during read", 32'(got), 32'(w));
    settle();
    chk("R6 dropped result not pending", {31'd0, drdyN}, 32'd1);
    csN = 1'b1;
    settle();
  endtask

  task automatic tOverwrite();
    logic [W-1:0] w1 = W'(32'h0000_1111);
    logic [W-1:0] w2 = W'(32'h0000_E00F);
    logic [W-1:0] got;
    pushResult(w1);
    pushResult(w2);
    csN = 1'b0;
    settle();
    readWord(got);
    chk("R6 overwrite while deselected", 32'(got), 32'(w2));
    csN = 1'b1;
    settle();
  endtask

  task automatic tAbort();
    logic [W-1:0] w = W'(32'h9B4E_2D71);
    logic [W-1:0] got;
    pushResult(w);
    csN = 1'b0;
    settle();
    for (int i = 0; i < 5; i++) begin
      clkEdge(1'b1);
      clkEdge(1'b0);
    end
    csN = 1'b1;
    settle();
    chk("R7 line released on deselect", {31'd0, sdoOe}, 32'd0);
    chk("R7 word still pending", {31'd0, drdyN}, 32'd0);
    csN = 1'b0;
    settle();
    chk("R7 restart at MSB", {31'd0, sdo}, {31'd0, w[W-1]});
    readWord(got);
    chk("R7 full word after restart", 32'(got), 32'(w));
    csN = 1'b1;
    settle();
  endtask

  task automatic tSelectFirst();
    logic [W-1:0] w = W'(32'h0000_8421);
    csN = 1'b0;
    settle();
    chk("R2 no drive without word", {31'd0, sdoOe}, 32'd0);
    chk("R2 quiet line low", {31'd0, sdo}, 32'd0);
    pushResult(w);
    chk("R2 drive when word arrives", {31'd0, sdoOe}, 32'd1);
    chk("R2 MSB after late word", {31'd0, sdo}, {31'd0, w[W-1]});
    csN = 1'b1;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    tReset();
    tReadLowIdle();
    tReadHighIdle();
    tDiscard();
    tOverwrite();
    tAbort();
    tSelectFirst();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule